// File: doc/BRIEF.md
# Asynchronous External Bus Controller

This block sits on the host side of a 16-bit asynchronous external bus, such as a link to an FPGA or an SRAM-like device. An internal request port supplies an address, write data, a read/write flag and a chip-select index. For each accepted request, the controller steps through a setup phase, a strobe phase and a hold phase. Each phase lasts a programmed number of interface cycles. During these phases the controller drives one active-low chip select, an output enable or a write enable, the address and, for writes, the data.

The interface logic advances once every six core clocks. This rate comes from a clock enable, not from a second clock. Each of the chip selects has its own timing word, with separate lengths for reads and writes and a turnaround length. The turnaround gap is placed in front of an access only when the access changes chip select or direction relative to the previous one. Read data is captured at the end of the strobe phase. It is returned with a single-cycle valid pulse on the core clock.

Top module: `async_bus_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. It goes low on the core clock edge that accepts a request (`req_valid` and `req_ready` both high), and it stays low until the edge on which that access's hold phase ends. When a turnaround is inserted, it also stays low through the turnaround.
- R2: Chip-select and strobe outputs change only on an interface tick, which occurs once every 6 core cycles. An accepted request waits for the next tick before its first phase starts. Back-to-back accesses without turnaround therefore leave every chip select high for exactly 6 core cycles between them.
- R3: For a write, the controller works through three phases. First, the selected chip select goes low with `bus_we_n` high for (wr_setup+1) interface cycles. Next, `bus_we_n` is low for (wr_strobe+1) cycles. Finally, `bus_we_n` is high again for (wr_hold+1) cycles while the chip select remains low.
- R4: A read follows the same three-phase pattern, using rd_setup, rd_strobe and rd_hold, with `bus_oe_n` as the strobe. `bus_oe_n` and `bus_we_n` are never low together.
- R5: The configuration is written with `cfg_we`, `cfg_idx` and `cfg_wdata`, and it resets to all zero. The timing word for each chip select has these fields: wr_setup [3:0], wr_strobe [7:4], wr_hold [11:8], rd_setup [15:12], rd_strobe [19:16], rd_hold [23:20] and turnaround [25:24]. An access uses the word of its own chip select only.
- R6: A field value of zero means one interface cycle. With all fields zero, an access holds the chip select low for 3 interface cycles (18 core cycles).
- R7: If the previous access used a different chip select or the opposite direction, a turnaround of (turnaround+1) interface cycles is inserted before setup, with all chip selects high. The turnaround length comes from the new access's timing word, and the chip-select gap becomes 6·(turnaround+2) core cycles. No turnaround is inserted for the same chip select in the same direction, or for the first access after reset.
- R8: On the tick that ends a read strobe, `bus_din` is captured into `rdata`. On that same edge, `rvalid` goes high for exactly one core cycle. Writes never raise `rvalid`.
- R9: `bus_doe` is high exactly while a write is in setup, strobe or hold. While it is high, `bus_dout` carries the request's write data.
- R10: At most one chip select is low at any time, and it is the one given by `req_cs` of the access in progress.
- R11: `bus_addr` holds the request address, unchanged, for as long as the chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a timing word |
| cfg_idx | input | 2 | Chip select whose timing word is written |
| cfg_wdata | input | 26 | Timing word value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select index |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| rvalid | output | 1 | One-cycle read-data valid pulse |
| rdata | output | 16 | Captured read data |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable (read strobe) |
| bus_we_n | output | 1 | Active-low write enable (write strobe) |
| bus_addr | output | 20 | External address |
| bus_dout | output | 16 | Data driven to the bus |
| bus_doe | output | 1 | Data output enable for the pad driver |
| bus_din | input | 16 | Data read from the bus |

## Verification
The assertions check, on every cycle, these per-cycle properties:
- Control edges line up with the divide-by-6 tick.
- The two strobes are never low together.
- At most one chip select is low.
- The data drive is confined to writes.
- The address holds steady while a chip select is low.
- The ready signal drops after acceptance.
- The read-valid pulse lasts one cycle.

Some behaviours cover a whole access and only the directed scenarios can show them. These are the exact phase lengths for the programmed fields, the choice of one chip select's timing word over another's, the decision whether to insert a turnaround, and the value returned for a read.

// File: rtl/abc_pkg.sv
package abc_pkg;

  localparam int PH_W = 4;
  localparam int TA_W = 2;

  // Per-chip-select timing word; field order fixes the bit layout of cfg_wdata.
  typedef struct packed {
    logic [TA_W-1:0] turn;
    logic [PH_W-1:0] rd_hold;
    logic [PH_W-1:0] rd_strobe;
    logic [PH_W-1:0] rd_setup;
    logic [PH_W-1:0] wr_hold;
    logic [PH_W-1:0] wr_strobe;
    logic [PH_W-1:0] wr_setup;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

endpackage

// File: rtl/abc_tick_gen.sv
module abc_tick_gen #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == CNT_W'(DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == CNT_W'(DIV - 1));
endmodule

// File: rtl/abc_cfg_bank.sv
module abc_cfg_bank import abc_pkg::*; #(
  parameter int NCS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [$clog2(NCS)-1:0] wr_idx,
  input  logic [CFG_W-1:0]       wr_data,
  input  logic [$clog2(NCS)-1:0] rd_idx,
  output cfg_t                   rd_cfg
);
  cfg_t regs [NCS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= cfg_t'(wr_data);
    end
  end

  assign rd_cfg = regs[rd_idx];
endmodule

// File: rtl/abc_seq.sv
module abc_seq import abc_pkg::*; #(
  parameter int NCS    = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [$clog2(NCS)-1:0] req_cs,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic [$clog2(NCS)-1:0] cur_cs,
  input  cfg_t                   cfg,
  output logic                   rvalid,
  output logic [DATA_W-1:0]      rdata,
  output logic [NCS-1:0]         bus_cs_n,
  output logic                   bus_oe_n,
  output logic                   bus_we_n,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [DATA_W-1:0]      bus_dout,
  output logic                   bus_doe,
  input  logic [DATA_W-1:0]      bus_din
);
  localparam int IDX_W = $clog2(NCS);

  phase_e            ph;
  logic [PH_W-1:0]   cnt;
  logic              write_q;
  logic [IDX_W-1:0]  cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              have_prev;
  logic [IDX_W-1:0]  prev_cs;
  logic              prev_write;

  logic [PH_W-1:0] len_setup, len_strobe, len_hold;
  logic            need_turn, active;

  assign len_setup  = write_q ? cfg.wr_setup  : cfg.rd_setup;
  assign len_strobe = write_q ? cfg.wr_strobe : cfg.rd_strobe;
  assign len_hold   = write_q ? cfg.wr_hold   : cfg.rd_hold;
  assign need_turn  = have_prev && ((prev_cs != cs_q) || (prev_write != write_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      write_q    <= 1'b0;
      cs_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      have_prev  <= 1'b0;
      prev_cs    <= '0;
      prev_write <= 1'b0;
      rvalid     <= 1'b0;
      rdata      <= '0;
    end else begin
      rvalid <= 1'b0;
      case (ph)
        PH_IDLE: if (req_valid) begin
          write_q <= req_write;
          cs_q    <= req_cs;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          ph      <= PH_WAIT;
        end
        PH_WAIT: if (tick) begin
          if (need_turn) begin
            ph  <= PH_TURN;
            cnt <= PH_W'(cfg.turn);
          end else begin
            ph  <= PH_SETUP;
            cnt <= len_setup;
          end
        end
        PH_TURN: if (tick) begin
          if (cnt == '0) begin
            ph  <= PH_SETUP;
            cnt <= len_setup;
          end else cnt <= cnt - 1'b1;
        end
        PH_SETUP: if (tick) begin
          if (cnt == '0) begin
            ph  <= PH_STROBE;
            cnt <= len_strobe;
          end else cnt <= cnt - 1'b1;
        end
        PH_STROBE: if (tick) begin
          if (cnt == '0) begin
            ph  <= PH_HOLD;
            cnt <= len_hold;
            if (!write_q) begin
              rdata  <= bus_din;
              rvalid <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        PH_HOLD: if (tick) begin
          if (cnt == '0) begin
            ph         <= PH_IDLE;
            have_prev  <= 1'b1;
            prev_cs    <= cs_q;
            prev_write <= write_q;
          end else cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign active    = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  assign req_ready = (ph == PH_IDLE);
  assign cur_cs    = cs_q;
  assign bus_oe_n  = !((ph == PH_STROBE) && !write_q);
  assign bus_we_n  = !((ph == PH_STROBE) && write_q);
  assign bus_addr  = addr_q;
  assign bus_dout  = wdata_q;
  assign bus_doe   = active && write_q;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign bus_cs_n[g] = !(active && (cs_q == IDX_W'(g)));
  end
endmodule

// File: rtl/async_bus_ctrl.sv
module async_bus_ctrl import abc_pkg::*; #(
  parameter int NCS     = 4,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int CLK_DIV = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [$clog2(NCS)-1:0] cfg_idx,
  input  logic [CFG_W-1:0]       cfg_wdata,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [$clog2(NCS)-1:0] req_cs,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rvalid,
  output logic [DATA_W-1:0]      rdata,
  output logic [NCS-1:0]         bus_cs_n,
  output logic                   bus_oe_n,
  output logic                   bus_we_n,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [DATA_W-1:0]      bus_dout,
  output logic                   bus_doe,
  input  logic [DATA_W-1:0]      bus_din
);
  localparam int IDX_W = $clog2(NCS);

  logic             tick_w;
  logic [IDX_W-1:0] cur_cs;
  cfg_t             cur_cfg;

  abc_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_w)
  );

  abc_cfg_bank #(.NCS(NCS)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_idx  (cur_cs),
    .rd_cfg  (cur_cfg)
  );

  abc_seq #(.NCS(NCS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cur_cs    (cur_cs),
    .cfg       (cur_cfg),
    .rvalid    (rvalid),
    .rdata     (rdata),
    .bus_cs_n  (bus_cs_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .bus_din   (bus_din)
  );
endmodule

// File: rtl/abc_chk.sv
module abc_chk #(
  parameter int NCS    = 4,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rvalid,
  input logic [NCS-1:0]    bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_we_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_doe
);
  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  tick_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(bus_cs_n) && $stable(bus_oe_n) && $stable(bus_we_n)));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n));

  // R8
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  // R9
  drive_window_chk: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> ((bus_cs_n != '1) && bus_oe_n));

  // R9
  we_needs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> bus_doe);

  // R10
  single_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_cs_n != '1) && ($past(bus_cs_n) == bus_cs_n)) |-> $stable(bus_addr));
endmodule

bind async_bus_ctrl abc_chk #(.NCS(NCS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick_w),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rvalid    (rvalid),
  .bus_cs_n  (bus_cs_n),
  .bus_oe_n  (bus_oe_n),
  .bus_we_n  (bus_we_n),
  .bus_addr  (bus_addr),
  .bus_doe   (bus_doe)
);

// File: tb/sim_async_bus_ctrl.sv
`timescale 1ns/1ps
module sim_async_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [25:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_cs = '0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rvalid;
  logic [15:0] rdata;
  logic [3:0]  bus_cs_n;
  logic        bus_oe_n, bus_we_n, bus_doe;
  logic [19:0] bus_addr;
  logic [15:0] bus_dout;
  logic [15:0] bus_din;

  always #2.5 clk = ~clk;

  // device model: drives a value derived from the address while output enable is low
  assign bus_din = !bus_oe_n ? (bus_addr[15:0] ^ 16'h5A3C) : 16'h0000;

  async_bus_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rvalid(rvalid), .rdata(rdata),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  int total = 0, bad = 0;
  longint cyc = 0;
  bit done = 0;

  logic [25:0] cfg_m [4];
  bit     has_prev = 0, chain = 0;
  int     prev_cs = 0;
  bit     prev_wr = 0;
  longint last_rise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int idx, input int ws, input int wt, input int wh,
                         input int rs, input int rt, input int rh, input int ta);
    logic [25:0] w;
    w = {ta[1:0], rh[3:0], rt[3:0], rs[3:0], wh[3:0], wt[3:0], ws[3:0]};
    cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m[idx] = w;
    chain = 0;
  endtask

  task automatic do_access(input int cs, input bit wr, input logic [19:0] a,
                           input logic [15:0] d);
    logic [25:0] c;
    int s, t, h, ta, nrv, tries;
    longint t_csf, t_csr, t_sf, t_sr, gap_exp;
    bit pc, ps, cl, sl, other_bad, rdy_bad, doe_ok, addr_bad;
    logic [15:0] rd, dout_s;
    c  = cfg_m[cs];
    s  = wr ? int'(c[3:0])  : int'(c[15:12]);
    t  = wr ? int'(c[7:4])  : int'(c[19:16]);
    h  = wr ? int'(c[11:8]) : int'(c[23:20]);
    ta = int'(c[25:24]);
    t_csf = -1; t_csr = -1; t_sf = -1; t_sr = -1;
    pc = 0; ps = 0; nrv = 0; other_bad = 0; rdy_bad = 0; doe_ok = 0; addr_bad = 0;
    rd = '0; dout_s = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = cs[1:0]; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    tries = 0;
    while (tries < 600) begin
      cl = !bus_cs_n[cs];
      sl = wr ? !bus_we_n : !bus_oe_n;
      if (cl && !pc) t_csf = cyc;
      if (!cl && pc) t_csr = cyc;
      if (sl && !ps) begin
        t_sf = cyc; dout_s = bus_dout; doe_ok = bus_doe;
      end
      if (!sl && ps) t_sr = cyc;
      if (cl && bus_addr != a) addr_bad = 1;
      if (((~bus_cs_n) & ~(4'b1 << cs)) != 4'b0) other_bad = 1;
      if (rvalid) begin nrv++; rd = rdata; end
      pc = cl; ps = sl;
      if (t_csr >= 0 && req_ready) break;
      if (req_ready) rdy_bad = 1;
      tries++;
      @(negedge clk);
    end
    chk(!rdy_bad, "R1", "ready stayed low during access", rdy_bad, 0);
    chk((t_csr - t_csf) == 6 * (s + t + h + 3), wr ? "R3" : "R4", "chip select low cycles",
        t_csr - t_csf, 6 * (s + t + h + 3));
    chk((t_sf - t_csf) == 6 * (s + 1), "R2", "setup core cycles", t_sf - t_csf, 6 * (s + 1));
    chk((t_sr - t_sf) == 6 * (t + 1), wr ? "R3" : "R4", "strobe core cycles",
        t_sr - t_sf, 6 * (t + 1));
    chk(!other_bad, "R10", "only requested chip select low", other_bad, 0);
    chk(!addr_bad, "R11", "address steady while selected", addr_bad, 0);
    if (wr) begin
      chk(nrv == 0, "R8", "no rvalid on write", nrv, 0);
      chk(doe_ok && dout_s == d, "R9", "write data driven", dout_s, d);
    end else begin
      chk(nrv == 1, "R8", "rvalid pulse count", nrv, 1);
      chk(rd == (a[15:0] ^ 16'h5A3C), "R8", "read data", rd, a[15:0] ^ 16'h5A3C);
    end
    if (has_prev && chain) begin
      gap_exp = (prev_cs != cs || prev_wr != wr) ? 6 * (ta + 2) : 6;
      chk((t_csf - last_rise) == gap_exp, "R7", "idle gap before access",
          t_csf - last_rise, gap_exp);
    end
    last_rise = t_csr; has_prev = 1; prev_cs = cs; prev_wr = wr; chain = 1;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(bus_cs_n == 4'hF, "R10", "chip selects idle after reset", bus_cs_n, 4'hF);
    chk(bus_oe_n && bus_we_n, "R4", "strobes idle after reset", {bus_oe_n, bus_we_n}, 3);
    chk(!bus_doe && !rvalid, "R9", "no drive after reset", {bus_doe, rvalid}, 0);
  endtask

  task automatic t_min_timing();
    // R6: all-zero words from reset, R7: first access has no turnaround
    do_access(0, 1, 20'h00012, 16'hBEEF);
    do_access(0, 1, 20'h00013, 16'h1234);
    do_access(0, 0, 20'h00100, 16'h0);
    do_access(0, 0, 20'h00101, 16'h0);
    chk(cfg_m[0] == 26'h0, "R6", "minimum fields used", cfg_m[0], 0);
  endtask

  task automatic t_write_phases();
    set_cfg(1, 2, 3, 1, 0, 0, 0, 1);
    do_access(1, 1, 20'hA0001, 16'hCAFE);
    do_access(1, 1, 20'hA0002, 16'h0F0F);
  endtask

  task automatic t_read_phases();
    set_cfg(1, 2, 3, 1, 1, 4, 2, 1);
    do_access(1, 0, 20'h5AA55, 16'h0);
    do_access(1, 0, 20'h0FFFF, 16'h0);
    do_access(1, 1, 20'h12345, 16'h7777);
  endtask

  task automatic t_per_cs();
    // R5: CS2 gets its own word, CS1 keeps its earlier one
    set_cfg(2, 0, 5, 0, 3, 0, 1, 2);
    do_access(2, 1, 20'h22222, 16'h2222);
    do_access(1, 1, 20'h11111, 16'h1111);
    do_access(2, 0, 20'h33333, 16'h0);
    do_access(1, 0, 20'h44444, 16'h0);
  endtask

  task automatic t_turnaround();
    set_cfg(3, 1, 1, 1, 1, 1, 1, 3);
    do_access(3, 1, 20'h00333, 16'h3333);
    do_access(0, 1, 20'h00334, 16'h4444);
    do_access(3, 1, 20'h00335, 16'h5555);
    do_access(3, 0, 20'h00336, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cfg_m[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_min_timing();
    t_write_phases();
    t_read_phases();
    t_per_cs();
    t_turnaround();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule